// File: doc/BRIEF.md
# Hit Record Binary Serializer

This block turns accepted detector hits into a packed byte stream that can be written straight to a storage file. After reset it sends a two-byte file header once. The header's low nibble is a 4-bit format code. Bit 3 of the code switches a waveform section on. Bits 2:0 pick the width of the energy field.

Each hit after the header becomes one variable-length record. The record starts with a fixed part: board, channel and timestamp. The energy field comes next, then the flags word. When waveforms are on, a waveform section follows: a waveform code byte, a sample count, and the samples themselves. The samples are pulled one at a time through a separate sample handshake. Every multi-byte field is sent least-significant byte first.

Output bytes leave through a valid/ready handshake. An end-of-record marker flags the final byte of each record. The serializer holds a single record. It opens its hit input again only after the previous record has completely drained.

Top module: `hit_rec_serializer`

## Requirements
- R1: After reset the first two bytes on the stream are {4'hE, fmt_code} and then 8'hCA. The header is sent exactly once per reset, and out_valid stays low afterwards until a hit is accepted.
- R2: hit_ready is low during reset and while any byte of the header or of a record is still unsent. It rises in the cycle after the final byte of a record is taken.
- R3: Each record starts with board (2 bytes), channel (2 bytes) and timestamp (8 bytes), each least-significant byte first.
- R4: The energy field follows the timestamp and depends on format bits 2:0:
  - 1 or 4: 2 bytes of hit_e_raw.
  - 2: 8 bytes of hit_e_cal.
  - 3: 2 bytes of hit_e_raw, then 8 bytes of hit_e_cal.
  - 0, 5, 6 or 7: no bytes.
- R5: The 4-byte flags word follows the energy field. When format bit 3 is clear, the record ends with the last flags byte.
- R6: When format bit 3 is set, the flags are followed by one waveform code byte and a 4-byte zero-extended sample count. After those, each sample is sent as 2 bytes, low byte first. Samples are taken through smp_valid/smp_ready, exactly hit_nsamp of them, in arrival order.
- R7: With format bit 3 set and a sample count of zero, the record ends with the last count byte, and no sample is requested.
- R8: out_last is high only on the final byte of a record and never on a header byte.
- R9: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values into the next cycle.
- R10: Every field of a record, including the format code that shapes it, is captured at hit acceptance. Changes to the hit inputs or to fmt_code after acceptance do not alter the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_code | input | 4 | Format code: bit 3 turns waveforms on, bits 2:0 set the energy width |
| hit_valid | input | 1 | Hit record offered |
| hit_ready | output | 1 | Serializer can take a hit |
| hit_board | input | 16 | Board number |
| hit_chan | input | 16 | Channel number |
| hit_stamp | input | 64 | Timestamp |
| hit_e_raw | input | 16 | Energy in ADC channels |
| hit_e_cal | input | 64 | Calibrated energy, 64-bit floating-point bit pattern |
| hit_flags | input | 32 | Hit flags |
| hit_wcode | input | 8 | Waveform code byte |
| hit_nsamp | input | CNT_W | Number of waveform samples |
| smp_valid | input | 1 | Waveform sample offered |
| smp_ready | output | 1 | Serializer takes a sample |
| smp_data | input | 16 | Waveform sample |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a record |

## Verification
The bench walks records through every energy width, including code 3's split field. Mixing up the order of the raw and calibrated parts of that field shows up as swapped bytes at offsets 12 to 21.

A waveform record with a zero sample count catches a design that asks for a phantom sample or places the end marker on the wrong byte. Irregular back-pressure catches output that drifts while it is stalled.

Hit inputs and the format code are scrambled right after acceptance. A design that reads them live, instead of from its captured copy, then corrupts the body of the record.

A reset in the middle of a record must bring the header back with the new format code. A record that is not fully drained must keep hit_ready low.

// File: rtl/hit_ser_pkg.sv
package hit_ser_pkg;

  typedef enum logic [2:0] {
    ST_HDR_LO,
    ST_HDR_HI,
    ST_IDLE,
    ST_FIXED,
    ST_WAVE
  } ser_state_e;

  typedef struct packed {
    logic [15:0] board;
    logic [15:0] chan;
    logic [63:0] stamp;
    logic [15:0] e_raw;
    logic [63:0] e_cal;
    logic [31:0] flags;
    logic [7:0]  wcode;
    logic [31:0] nsamp;
    logic [3:0]  fmt;
  } hit_rec_t;

  // file tag, upper 12 bits of the 16-bit header
  localparam logic [11:0] HDR_TAG = 12'hCAE;

  // fixed-part byte offsets
  localparam logic [4:0] OFF_CHAN   = 5'd2;
  localparam logic [4:0] OFF_STAMP  = 5'd4;
  localparam logic [4:0] OFF_ENERGY = 5'd12;

  function automatic logic has_wave(logic [3:0] fmt);
    return fmt[3];
  endfunction

  function automatic logic [4:0] energy_bytes(logic [3:0] fmt);
    case (fmt[2:0])
      3'd1, 3'd4: return 5'd2;
      3'd2:       return 5'd8;
      3'd3:       return 5'd10;
      default:    return 5'd0;
    endcase
  endfunction

  // bytes before the first waveform sample
  function automatic logic [4:0] fixed_len(logic [3:0] fmt);
    return OFF_ENERGY + energy_bytes(fmt) + 5'd4 + (has_wave(fmt) ? 5'd5 : 5'd0);
  endfunction

  function automatic logic [7:0] le_byte(logic [63:0] v, logic [2:0] k);
    return v[{k, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/hit_ser_field_mux.sv
module hit_ser_field_mux
  import hit_ser_pkg::*;
(
  input  hit_rec_t   rec,
  input  logic [4:0] idx,
  output logic [7:0] fb_data
);

  logic [4:0] e_len, off_flags, off_wcode, off_count, rel;

  always_comb begin
    e_len     = energy_bytes(rec.fmt);
    off_flags = OFF_ENERGY + e_len;
    off_wcode = off_flags + 5'd4;
    off_count = off_wcode + 5'd1;
    rel       = 5'd0;
    fb_data   = 8'h00;
    if (idx < OFF_CHAN) begin
      fb_data = le_byte({48'b0, rec.board}, idx[2:0]);
    end else if (idx < OFF_STAMP) begin
      rel     = idx - OFF_CHAN;
      fb_data = le_byte({48'b0, rec.chan}, rel[2:0]);
    end else if (idx < OFF_ENERGY) begin
      rel     = idx - OFF_STAMP;
      fb_data = le_byte(rec.stamp, rel[2:0]);
    end else if (idx < off_flags) begin
      rel = idx - OFF_ENERGY;
      case (rec.fmt[2:0])
        3'd2: fb_data = le_byte(rec.e_cal, rel[2:0]);
        3'd3: begin
          if (rel < 5'd2) fb_data = le_byte({48'b0, rec.e_raw}, rel[2:0]);
          else begin
            rel     = rel - 5'd2;
            fb_data = le_byte(rec.e_cal, rel[2:0]);
          end
        end
        default: fb_data = le_byte({48'b0, rec.e_raw}, rel[2:0]);
      endcase
    end else if (idx < off_wcode) begin
      rel     = idx - off_flags;
      fb_data = le_byte({32'b0, rec.flags}, rel[2:0]);
    end else if (idx == off_wcode) begin
      fb_data = rec.wcode;
    end else begin
      rel     = idx - off_count;
      fb_data = le_byte({32'b0, rec.nsamp}, rel[2:0]);
    end
  end

endmodule

// File: rtl/hit_ser_wave.sv
module hit_ser_wave #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [15:0]      smp_data_i,
  input  logic             smp_valid_i,
  output logic             smp_ready_o,
  input  logic             take_i,
  output logic             valid_o,
  output logic [7:0]       data_o,
  output logic             last_o,
  output logic             active_o
);

  typedef enum logic [1:0] {W_OFF, W_FETCH, W_LO, W_HI} wave_phase_e;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  wave_phase_e      phase;
  logic [15:0]      hold;
  logic [CNT_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= W_OFF;
      hold  <= '0;
      rem   <= '0;
    end else begin
      case (phase)
        W_OFF: if (start_i) begin
          rem   <= count_i;
          phase <= W_FETCH;
        end
        W_FETCH: if (smp_valid_i) begin
          hold  <= smp_data_i;
          phase <= W_LO;
        end
        W_LO: if (take_i) phase <= W_HI;
        W_HI: if (take_i) begin
          if (rem == ONE) phase <= W_OFF;
          else begin
            rem   <= rem - ONE;
            phase <= W_FETCH;
          end
        end
        default: phase <= W_OFF;
      endcase
    end
  end

  assign smp_ready_o = (phase == W_FETCH);
  assign valid_o     = (phase == W_LO) || (phase == W_HI);
  assign data_o      = (phase == W_HI) ? hold[15:8] : hold[7:0];
  assign last_o      = (phase == W_HI) && (rem == ONE);
  assign active_o    = (phase != W_OFF);

  AST_FETCH_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready_o |-> !valid_o);  // R6
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !active_o && count_i != '0);  // R7
  AST_HIGH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && take_i && !last_o && phase == W_LO) |=> valid_o);  // R6

endmodule

// File: rtl/hit_rec_serializer.sv
module hit_rec_serializer
  import hit_ser_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       fmt_code,
  input  logic             hit_valid,
  output logic             hit_ready,
  input  logic [15:0]      hit_board,
  input  logic [15:0]      hit_chan,
  input  logic [63:0]      hit_stamp,
  input  logic [15:0]      hit_e_raw,
  input  logic [63:0]      hit_e_cal,
  input  logic [31:0]      hit_flags,
  input  logic [7:0]       hit_wcode,
  input  logic [CNT_W-1:0] hit_nsamp,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [15:0]      smp_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last
);

  ser_state_e state;
  hit_rec_t   rec;
  logic [4:0] idx;

  // named internal events
  logic       out_fire, rec_accept, fixed_end, wave_go, wave_start;
  logic       w_valid, w_last, w_active;
  logic [7:0] fixed_byte, w_byte;

  assign out_fire   = out_valid && out_ready;
  assign rec_accept = hit_valid && hit_ready;
  assign fixed_end  = (idx == fixed_len(rec.fmt) - 5'd1);
  assign wave_go    = has_wave(rec.fmt) && (rec.nsamp != 32'd0);
  assign wave_start = (state == ST_FIXED) && out_fire && fixed_end && wave_go;

  hit_ser_field_mux u_mux (
    .rec     (rec),
    .idx     (idx),
    .fb_data (fixed_byte)
  );

  hit_ser_wave #(.CNT_W(CNT_W)) u_wave (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (wave_start),
    .count_i     (rec.nsamp[CNT_W-1:0]),
    .smp_data_i  (smp_data),
    .smp_valid_i (smp_valid),
    .smp_ready_o (smp_ready),
    .take_i      (out_ready && state == ST_WAVE),
    .valid_o     (w_valid),
    .data_o      (w_byte),
    .last_o      (w_last),
    .active_o    (w_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_HDR_LO;
      idx   <= '0;
      rec   <= '0;
    end else begin
      case (state)
        ST_HDR_LO: if (out_fire) state <= ST_HDR_HI;
        ST_HDR_HI: if (out_fire) state <= ST_IDLE;
        ST_IDLE: if (rec_accept) begin
          rec <= '{board: hit_board, chan: hit_chan, stamp: hit_stamp,
                   e_raw: hit_e_raw, e_cal: hit_e_cal, flags: hit_flags,
                   wcode: hit_wcode, nsamp: 32'(hit_nsamp), fmt: fmt_code};
          idx   <= '0;
          state <= ST_FIXED;
        end
        ST_FIXED: if (out_fire) begin
          if (fixed_end) state <= wave_go ? ST_WAVE : ST_IDLE;
          else           idx   <= idx + 5'd1;
        end
        ST_WAVE: if (out_fire && w_last) state <= ST_IDLE;
        default: state <= ST_HDR_LO;
      endcase
    end
  end

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'h00;
    out_last  = 1'b0;
    case (state)
      ST_HDR_LO: begin out_valid = 1'b1; out_data = {HDR_TAG[3:0], fmt_code}; end
      ST_HDR_HI: begin out_valid = 1'b1; out_data = HDR_TAG[11:4]; end
      ST_FIXED: begin
        out_valid = 1'b1;
        out_data  = fixed_byte;
        out_last  = fixed_end && !wave_go;
      end
      ST_WAVE: begin
        out_valid = w_valid;
        out_data  = w_byte;
        out_last  = w_last;
      end
      default: ;
    endcase
  end

  assign hit_ready = (state == ST_IDLE);

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));  // R9
  AST_NO_ACCEPT_MID_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ready |-> !out_valid && !w_active);  // R2
  AST_LAST_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> hit_ready);  // R8
  AST_HDR_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HDR_LO || state == ST_HDR_HI) |-> !out_last);  // R1
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIXED) |-> idx < fixed_len(rec.fmt));  // R5

endmodule

// File: tb/tb_hit_rec_serializer.sv
module tb_hit_rec_serializer;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic             rst_n, hit_valid, hit_ready, smp_valid, smp_ready;
  logic             out_valid, out_ready, out_last;
  logic [3:0]       fmt_code;
  logic [15:0]      hit_board, hit_chan, hit_e_raw, smp_data;
  logic [63:0]      hit_stamp, hit_e_cal;
  logic [31:0]      hit_flags;
  logic [7:0]       hit_wcode, out_data;
  logic [CNT_W-1:0] hit_nsamp;

  hit_rec_serializer #(.CNT_W(CNT_W)) dut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  fmt;
    logic [15:0] board;
    logic [15:0] chan;
    logic [63:0] stamp;
    logic [15:0] e_raw;
    logic [63:0] e_cal;
    logic [31:0] flags;
    logic [7:0]  wcode;
    logic [7:0]  nsamp;
    logic        stall;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'h1, 16'h0102, 16'h0304, 64'h1122334455667788, 16'hBEEF, 64'h0, 32'hA1B2C3D4, 8'h00, 8'd0, 1'b0},
    '{4'h2, 16'h00FF, 16'h000F, 64'hFEDCBA9876543210, 16'h1234, 64'h4059000000000001, 32'h00000001, 8'h00, 8'd0, 1'b1},
    '{4'h3, 16'h8001, 16'h0007, 64'h00000000DEADBEEF, 16'hCAFE, 64'h0123456789ABCDEF, 32'h80000000, 8'h00, 8'd0, 1'b0},
    '{4'h4, 16'h0A0B, 16'h0C0D, 64'h0F0E0D0C0B0A0908, 16'h5AA5, 64'h0, 32'h13572468, 8'h00, 8'd0, 1'b1},
    '{4'h9, 16'h0011, 16'h0022, 64'h0000000100000002, 16'h7001, 64'h0, 32'h0000FFFF, 8'h3C, 8'd3, 1'b1},
    '{4'hB, 16'h0033, 16'h0044, 64'h9999888877776666, 16'h0102, 64'h1020304050607080, 32'hFFFF0000, 8'h01, 8'd0, 1'b0},
    '{4'h0, 16'h0055, 16'h0066, 64'h0000000000000077, 16'hFFFF, 64'hFFFFFFFFFFFFFFFF, 32'h00C0FFEE, 8'h00, 8'd0, 1'b1},
    '{4'hA, 16'h0077, 16'h0088, 64'hABCDEF0123456789, 16'h0000, 64'h3FF0000000000000, 32'h11223344, 8'h7E, 8'd5, 1'b0}
  };

  function automatic logic [15:0] sample_val(input int v, input int k);
    return 16'(((v & 15) << 12) | ((k & 15) << 8) | ((k * 37 + v * 5) & 255));
  endfunction

  logic [7:0] exp_q[$];
  string      exp_req[$];
  int         cur_vi, ks;

  task automatic put(input logic [63:0] v, input int n, input string r);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v[8*i +: 8]);
      exp_req.push_back(r);
    end
  endtask

  task automatic build(input vec_t v, input int vi);
    exp_q.delete();
    exp_req.delete();
    put({48'b0, v.board}, 2, "R3");
    put({48'b0, v.chan}, 2, "R3");
    put(v.stamp, 8, "R3");
    case (v.fmt[2:0])
      3'd1, 3'd4: put({48'b0, v.e_raw}, 2, "R4");
      3'd2:       put(v.e_cal, 8, "R4");
      3'd3: begin put({48'b0, v.e_raw}, 2, "R4"); put(v.e_cal, 8, "R4"); end
      default: ;
    endcase
    put({32'b0, v.flags}, 4, "R5");
    if (v.fmt[3]) begin
      put({56'b0, v.wcode}, 1, "R6");
      put({56'b0, v.nsamp}, 4, (v.nsamp == 0) ? "R7" : "R6");
      for (int k = 0; k < int'(v.nsamp); k++) put({48'b0, sample_val(vi, k)}, 2, "R6");
    end
  endtask

  task automatic consume(input bit stall, input bit is_record, input int nsamp);
    int pos = 0, cyc = 0;
    bit prev_stall = 0;
    logic [7:0] pd = '0;
    logic pl = 0;
    ks = 0;
    while (pos < exp_q.size() && cyc < 400) begin
      @(negedge clk);
      out_ready = stall ? ((cyc % 3) == 1) : 1'b1;
      smp_valid = (ks < nsamp);
      smp_data  = sample_val(cur_vi, ks);
      #1;
      if (prev_stall)
        check(out_valid && out_data == pd && out_last == pl, "R9", "held byte",
              {55'b0, out_valid, out_data}, {55'b0, 1'b1, pd});
      check(!hit_ready, "R2", "ready while busy", 64'(hit_ready), 64'd0);
      if (out_valid && out_ready) begin
        check(out_data == exp_q[pos], exp_req[pos], $sformatf("byte %0d", pos),
              64'(out_data), 64'(exp_q[pos]));
        check(out_last == (is_record && pos == exp_q.size() - 1), "R8",
              $sformatf("last at byte %0d", pos), 64'(out_last),
              64'(is_record && pos == exp_q.size() - 1));
        pos++;
      end
      if (smp_valid && smp_ready) ks++;
      prev_stall = out_valid && !out_ready;
      pd = out_data;
      pl = out_last;
      cyc++;
    end
    check(pos == exp_q.size(), "R2", "bytes drained", 64'(pos), 64'(exp_q.size()));
    @(negedge clk);
    out_ready = 1'b1;
    smp_valid = 1'b0;
    #1;
    if (is_record) begin
      check(ks == nsamp, (nsamp == 0) ? "R7" : "R6", "samples pulled", 64'(ks), 64'(nsamp));
      check(hit_ready && !out_valid, "R2", "ready after record",
            {62'b0, hit_ready, out_valid}, 64'b10);
    end
  endtask

  task automatic send(input vec_t v, input int vi);
    @(negedge clk);
    cur_vi    = vi;
    fmt_code  = v.fmt;
    hit_board = v.board;  hit_chan  = v.chan;   hit_stamp = v.stamp;
    hit_e_raw = v.e_raw;  hit_e_cal = v.e_cal;  hit_flags = v.flags;
    hit_wcode = v.wcode;  hit_nsamp = CNT_W'(v.nsamp);
    hit_valid = 1'b1;
    #1;
    check(hit_ready, "R2", "ready before hit", 64'(hit_ready), 64'd1);
    @(posedge clk);
    #1;
    // R10: scramble inputs after acceptance
    hit_valid = 1'b0;
    fmt_code  = ~v.fmt;
    hit_board = ~v.board; hit_chan  = ~v.chan;  hit_stamp = ~v.stamp;
    hit_e_raw = ~v.e_raw; hit_e_cal = ~v.e_cal; hit_flags = ~v.flags;
    hit_wcode = ~v.wcode; hit_nsamp = CNT_W'(8'(~v.nsamp));
  endtask

  task automatic do_reset(input logic [3:0] f);
    @(negedge clk);
    rst_n = 1'b0;
    fmt_code = f;
    out_ready = 1'b0;
    hit_valid = 1'b0;
    smp_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(!hit_ready, "R2", "reset ready", 64'(hit_ready), 64'd0);
    check(!out_last, "R8", "reset last", 64'(out_last), 64'd0);
    check(out_valid && out_data == {4'hE, f}, "R1", "reset header byte",
          64'(out_data), 64'({4'hE, f}));
    rst_n = 1'b1;
  endtask

  task automatic header(input logic [3:0] f);
    exp_q.delete();
    exp_req.delete();
    put({56'b0, 4'hE, f}, 1, "R1");
    put(64'hCA, 1, "R1");
    consume(1'b1, 1'b0, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1;
      check(!out_valid && hit_ready, "R1", "no repeated header",
            {62'b0, out_valid, hit_ready}, 64'b01);
    end
  endtask

  initial begin
    hit_board = '0; hit_chan = '0; hit_stamp = '0; hit_e_raw = '0;
    hit_e_cal = '0; hit_flags = '0; hit_wcode = '0; hit_nsamp = '0;
    smp_data = '0; cur_vi = 0; ks = 0;
    rst_n = 1'b0;
    do_reset(4'h9);
    header(4'h9);
    for (int vi = 0; vi < NV; vi++) begin
      build(VECS[vi], vi);
      send(VECS[vi], vi);
      consume(VECS[vi].stall, 1'b1, int'(VECS[vi].nsamp));
    end
    // reset during a record restarts with a fresh header
    send(VECS[7], 7);
    repeat (3) @(posedge clk);
    do_reset(4'h3);
    header(4'h3);
    build(VECS[2], 2);
    send(VECS[2], 2);
    consume(1'b1, 1'b1, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule